// File: doc/BRIEF.md
# Clock Divider and Fan-out Stage

This block is the digital back end of a phase-locked clock driver. It picks a source clock and divides it into a family of related clocks. In normal operation the source is an oscillator clock that arrives on a port. The loop that produces that clock lies outside this block. In bypass mode the source is one of two reference clocks, chosen by a select pin. Bypass mode is meant for slow board testing, so any reference frequency works.

The block produces a double-rate clock, a bank of in-phase base-rate clocks, one base-rate clock of opposite phase, and a half-rate clock. A rate control can insert an extra divide-by-two ahead of all outputs. A combined active-low reset and output enable puts every clock output into high impedance and clears the dividers at once. A lock indication from the analog loop is passed through, gated by the mode.

The block works in bypass mode from the falling edge of the reference. As a result, output phase in bypass mode is the opposite of normal mode.

Top module: `clk_fanout_div`

## Requirements
- R1: `ref_sel` low selects `ref_a` and high selects `ref_b`. In bypass mode, edges on the reference that is not selected leave every output unchanged.
- R2: With `pll_on` high, the dividers run from rising edges of `osc_clk`. With `pll_on` low, they run from falling edges of the selected reference, and `osc_clk` has no effect.
- R3: In bypass mode with `rate_hi` high, `dbl_clk` is the inverse of the selected reference. The base clocks divide it by 2 and `half_clk` divides it by 4, and all changes occur on the reference's falling edge.
- R4: With `rate_hi` low, an extra divide-by-2 stage halves every output. In bypass mode, `dbl_clk`, the base clocks and `half_clk` then divide the reference by 2, 4 and 8.
- R5: In normal mode, `dbl_clk` runs at twice the base rate and `half_clk` at half the base rate. With `rate_hi` high, the base clocks toggle on every oscillator rising edge. `half_clk` toggles on each edge where the base clocks are high.
- R6: While outputs are enabled, `base_clk_n` is always the opposite of `base_clk`.
- R7: All lanes of `base_clk` toggle on the same edge and always carry equal values.
- R8: While `oe_rst_n` is low, every clock output is high impedance and the divider registers are cleared asynchronously. After release and before the first source edge, `base_clk` is all 0, `base_clk_n` is 1, `half_clk` is 0 and `dbl_clk` is 0.
- R9: `lock_out` equals `lock_in` while `pll_on` is high and is 0 while `pll_on` is low. It is never tri-stated.
- R10: Output polarity is complementary between the modes. The first base rising edge after release follows the first oscillator rising edge in normal mode, and the first reference falling edge in bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock from the external loop |
| ref_a | input | 1 | Reference clock, choice 0 |
| ref_b | input | 1 | Reference clock, choice 1 |
| ref_sel | input | 1 | Reference choice: 0 = ref_a, 1 = ref_b |
| pll_on | input | 1 | 1 = normal mode, 0 = bypass from reference |
| rate_hi | input | 1 | 1 = no extra divide, 0 = extra divide-by-2 |
| oe_rst_n | input | 1 | Active-low asynchronous clear and output disable |
| lock_in | input | 1 | Lock indication from the analog loop |
| dbl_clk | output | 1 | Double-rate clock, tri-stateable |
| base_clk | output | BASE_LANES | In-phase base-rate clocks, tri-stateable |
| base_clk_n | output | 1 | Opposite-phase base-rate clock, tri-stateable |
| half_clk | output | 1 | Half-rate clock, tri-stateable |
| lock_out | output | 1 | Mode-gated lock indication |

## Verification
On every second edge of the divided source clock, the base clocks and the half-rate clock toggle together. The half-rate register decides from the base value sampled on that same edge. The bench counts rising edges of each output over windows of 7 to 32 source edges, in all four mode and rate pairs. Exact counts and the final output levels show whether both toggles landed on the shared edge. A run that stops with base and half both high is followed by a reset pulse, to show that the asynchronous clear wins over a pending toggle.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int unsigned DEF_LANES = 5;
  typedef enum logic {PICK_A = 1'b0, PICK_B = 1'b1} ref_pick_e;
  typedef enum logic {SRC_REF = 1'b0, SRC_OSC = 1'b1} src_kind_e;
endpackage

// File: rtl/cfd_src_mux.sv
module cfd_src_mux (
  input  logic osc_clk,
  input  logic ref_a,
  input  logic ref_b,
  input  logic ref_sel,
  input  logic pll_on,
  output logic src_clk
);
  import cfd_pkg::*;
  logic ref_pick;

  // chosen reference feeds the bypass path; inverted so that the
  // dividers' rising-edge flops act on the reference falling edge
  assign ref_pick = (ref_pick_e'(ref_sel) == PICK_B) ? ref_b : ref_a;
  assign src_clk  = (src_kind_e'(pll_on) == SRC_OSC) ? osc_clk : ~ref_pick;
endmodule

// File: rtl/cfd_prescale.sv
module cfd_prescale #(
  parameter bit PRE_EN = 1'b1
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic rate_hi,
  output logic stage_clk
);
  if (PRE_EN) begin : g_pre
    logic pre_q;
    always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) pre_q <= 1'b0;
      else        pre_q <= ~pre_q;
    end
    assign stage_clk = rate_hi ? src_clk : pre_q;
  end else begin : g_nopre
    assign stage_clk = src_clk;
  end
endmodule

// File: rtl/cfd_divbank.sv
module cfd_divbank #(
  parameter int unsigned LANES = 5
) (
  input  logic             stage_clk,
  input  logic             rst_n,
  output logic [LANES-1:0] lane_q,
  output logic             lane_n,
  output logic             half_q
);
  logic opp_q;
  logic half_r;

  // one register per lane so each output has its own driver
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic q;
    always_ff @(posedge stage_clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ~q;
    end
    assign lane_q[g] = q;
  end

  always_ff @(posedge stage_clk or negedge rst_n) begin
    if (!rst_n) opp_q <= 1'b0;
    else        opp_q <= ~opp_q;
  end

  always_ff @(posedge stage_clk or negedge rst_n) begin
    if (!rst_n) half_r <= 1'b0;
    else        half_r <= half_r ^ lane_q[0];
  end

  assign lane_n = ~opp_q;
  assign half_q = half_r;
endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div #(
  parameter int unsigned BASE_LANES = cfd_pkg::DEF_LANES,
  parameter bit          PRE_EN     = 1'b1
) (
  input  logic                  osc_clk,
  input  logic                  ref_a,
  input  logic                  ref_b,
  input  logic                  ref_sel,
  input  logic                  pll_on,
  input  logic                  rate_hi,
  input  logic                  oe_rst_n,
  input  logic                  lock_in,
  output logic                  dbl_clk,
  output logic [BASE_LANES-1:0] base_clk,
  output logic                  base_clk_n,
  output logic                  half_clk,
  output logic                  lock_out
);
  logic                  src_clk;
  logic                  stage_clk;
  logic [BASE_LANES-1:0] lane_q;
  logic                  lane_n;
  logic                  half_q;

  cfd_src_mux u_mux (
    .osc_clk (osc_clk),
    .ref_a   (ref_a),
    .ref_b   (ref_b),
    .ref_sel (ref_sel),
    .pll_on  (pll_on),
    .src_clk (src_clk)
  );

  cfd_prescale #(.PRE_EN(PRE_EN)) u_pre (
    .src_clk   (src_clk),
    .rst_n     (oe_rst_n),
    .rate_hi   (rate_hi),
    .stage_clk (stage_clk)
  );

  cfd_divbank #(.LANES(BASE_LANES)) u_div (
    .stage_clk (stage_clk),
    .rst_n     (oe_rst_n),
    .lane_q    (lane_q),
    .lane_n    (lane_n),
    .half_q    (half_q)
  );

  assign dbl_clk    = oe_rst_n ? stage_clk : 1'bz;
  assign base_clk   = oe_rst_n ? lane_q : {BASE_LANES{1'bz}};
  assign base_clk_n = oe_rst_n ? lane_n : 1'bz;
  assign half_clk   = oe_rst_n ? half_q : 1'bz;
  assign lock_out   = pll_on & lock_in;
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
  parameter int unsigned LANES = 5
) (
  input logic             osc_clk,
  input logic             oe_rst_n,
  input logic             pll_on,
  input logic             rate_hi,
  input logic             lock_in,
  input logic             lock_out,
  input logic [LANES-1:0] base_clk,
  input logic             base_clk_n,
  input logic             half_clk
);
  AST_LANES_EQUAL: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
    base_clk == {LANES{base_clk[0]}}); // R7

  AST_INV_OPPOSITE: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
    base_clk_n != base_clk[0]); // R6

  AST_LOCK_GATED: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
    !pll_on |-> !lock_out); // R9

  AST_LOCK_FOLLOWS: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
    pll_on |-> (lock_out == lock_in)); // R9

  AST_BASE_TOGGLES: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
    (pll_on && rate_hi) |=> (base_clk[0] != $past(base_clk[0]))); // R5

  AST_HALF_TOGGLES: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
    (pll_on && rate_hi && base_clk[0]) |=> (half_clk != $past(half_clk))); // R5
endmodule

bind clk_fanout_div cfd_checker #(.LANES(BASE_LANES)) u_chk (
  .osc_clk    (osc_clk),
  .oe_rst_n   (oe_rst_n),
  .pll_on     (pll_on),
  .rate_hi    (rate_hi),
  .lock_in    (lock_in),
  .lock_out   (lock_out),
  .base_clk   (base_clk),
  .base_clk_n (base_clk_n),
  .half_clk   (half_clk)
);

// File: tb/clk_fanout_div_tb.sv
module clk_fanout_div_tb;
  localparam int L = 5;

  logic osc_clk = 1'b0;
  logic ref_a = 1'b1, ref_b = 1'b1, ref_sel = 1'b0;
  logic pll_on = 1'b1, rate_hi = 1'b1, oe_rst_n = 1'b0, lock_in = 1'b0;
  logic dbl_clk, base_clk_n, half_clk, lock_out;
  logic [L-1:0] base_clk;

  int checks = 0, errors = 0;
  int n_dbl = 0, n_half = 0, n_inv = 0;
  int n_lane [L];
  logic pd = 1'b0, ph = 1'b0, pi = 1'b0;
  logic [L-1:0] pb = '0;

  always #5 osc_clk = ~osc_clk;

  clk_fanout_div #(.BASE_LANES(L)) u_dut (
    .osc_clk(osc_clk), .ref_a(ref_a), .ref_b(ref_b), .ref_sel(ref_sel),
    .pll_on(pll_on), .rate_hi(rate_hi), .oe_rst_n(oe_rst_n), .lock_in(lock_in),
    .dbl_clk(dbl_clk), .base_clk(base_clk), .base_clk_n(base_clk_n),
    .half_clk(half_clk), .lock_out(lock_out)
  );

  always @(dbl_clk) begin
    if (pd === 1'b0 && dbl_clk === 1'b1) n_dbl++;
    pd = dbl_clk;
  end
  always @(half_clk) begin
    if (ph === 1'b0 && half_clk === 1'b1) n_half++;
    ph = half_clk;
  end
  always @(base_clk_n) begin
    if (pi === 1'b1 && base_clk_n === 1'b0) n_inv++;
    pi = base_clk_n;
  end
  always @(base_clk) begin
    for (int i = 0; i < L; i++)
      if (pb[i] === 1'b0 && base_clk[i] === 1'b1) n_lane[i]++;
    pb = base_clk;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // passes for high impedance or 0, fails on a driven 1
  task automatic chk_not1(input string req, input logic v, input string what);
    checks++;
    if (v === 1'b1) begin
      errors++;
      $display("FAIL %s %s: actual 1 expected z", req, what);
    end
  endtask

  task automatic clear_counts();
    n_dbl = 0; n_half = 0; n_inv = 0;
    for (int i = 0; i < L; i++) n_lane[i] = 0;
  endtask

  task automatic drive_ref(input logic which, input logic v);
    if (which) ref_b = v; else ref_a = v;
  endtask

  task automatic run_window(input logic pll, input logic hi, input logic sel, input int k);
    int m;
    @(negedge osc_clk);
    oe_rst_n = 1'b0;
    pll_on = pll; rate_hi = hi; ref_sel = sel;
    ref_a = 1'b1; ref_b = 1'b1;
    #1;
    chk_not1("R8", base_clk_n, "inverted output during reset");
    chk_not1("R8", half_clk, "half output during reset");
    @(negedge osc_clk);
    @(negedge osc_clk);
    oe_rst_n = 1'b1;
    #1;
    chk("R8", base_clk, 0, "base after release");
    chk("R8", base_clk_n, 1, "inverted after release");
    chk("R8", half_clk, 0, "half after release");
    chk("R8", dbl_clk, 0, "double after release");
    clear_counts();
    if (pll) begin
      for (int i = 0; i < k; i++) begin
        @(posedge osc_clk); #1;
        if (i == 0) chk("R10", base_clk[0], 1, "normal: base high after first osc rise");
        checks++;
        if (base_clk !== '0 && base_clk !== '1) begin
          errors++; $display("FAIL R7 lanes differ: actual %b expected uniform", base_clk);
        end
      end
    end else begin
      // R1: unselected reference must do nothing
      for (int i = 0; i < 8; i++) begin
        drive_ref(~sel, 1'b0); #20; drive_ref(~sel, 1'b1); #20;
      end
      chk("R1", n_dbl + n_lane[0] + n_half, 0, "edges from unselected reference");
      chk("R1", base_clk, 0, "base after unselected toggles");
      for (int i = 0; i < k; i++) begin
        drive_ref(sel, 1'b0); #1;
        if (i == 0) chk("R10", base_clk[0], 1, "bypass: base high after first ref fall");
        if (hi) chk("R3", dbl_clk, 1, "double is inverse of low reference");
        #19;
        drive_ref(sel, 1'b1); #1;
        if (hi) chk("R3", dbl_clk, 0, "double is inverse of high reference");
        #19;
      end
    end
    #1;
    m = hi ? k : k / 2;
    chk(hi ? "R2" : "R4", n_dbl, m, "double-rate rising edges");
    for (int i = 0; i < L; i++) chk("R7", n_lane[i], (m + 1) / 2, "base lane rising edges");
    chk("R6", n_inv, (m + 1) / 2, "inverted output falling edges");
    chk(pll ? "R5" : "R3", n_half, (m + 2) / 4, "half-rate rising edges");
    chk("R5", half_clk, (m / 2) % 2, "half level at end");
    chk("R6", base_clk_n, 1 - (m % 2), "inverted level at end");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 lock gating, also while outputs disabled
    @(negedge osc_clk);
    pll_on = 1'b1; lock_in = 1'b1; #1;
    chk("R9", lock_out, 1, "lock passes in normal mode under reset");
    lock_in = 1'b0; #1;
    chk("R9", lock_out, 0, "lock low follows");
    pll_on = 1'b0; lock_in = 1'b1; #1;
    chk("R9", lock_out, 0, "lock forced low in bypass");

    // R2 R5 normal mode, both rates
    run_window(1'b1, 1'b1, 1'b0, 32);
    run_window(1'b1, 1'b0, 1'b0, 32);
    // R3 R4 bypass, both rates and both references
    run_window(1'b0, 1'b1, 1'b0, 32);
    run_window(1'b0, 1'b0, 1'b0, 32);
    run_window(1'b0, 1'b1, 1'b1, 16);
    run_window(1'b0, 1'b0, 1'b1, 24);
    // stop with base and half high, then reset clears them (R8 in next run)
    run_window(1'b1, 1'b1, 1'b0, 7);
    run_window(1'b1, 1'b0, 1'b1, 12);

    @(negedge osc_clk);
    pll_on = 1'b1; lock_in = 1'b1; #1;
    chk("R9", lock_out, 1, "lock passes with outputs enabled");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule